// File: doc/BRIEF.md
# Command Completion Event Counter with Interrupt

This block is the per-channel completion status register of a DMA channel. Each pulse from the data mover advances a 6-bit hardware count of finished events. The first pulse of a transfer marks that the command list has been loaded. Each later pulse marks one completed command. Software keeps its own 6-bit acknowledged count in the same register. The number of unserviced events is the hardware count minus the acknowledged count, modulo 64. A sticky event flag records that at least one increment has happened since software last cleared it.

The interrupt line is active high and is gated by two enable bits in a small configuration register. A third configuration bit selects the mode:
- **Level mode:** the line stays high for as long as the two counts differ.
- **Pulse mode:** the line is high for one cycle after each increment.

Software acknowledges events in one write. That write copies the done count it observed into the acknowledged field and clears the flag. If the mover finishes another command in the same cycle, that increment is still counted and the line stays high.

The block also shows the mover's remaining byte count for the command in flight. The count is stored minus one, so a field of all ones is ambiguous. For that reason the largest command is kept one bus width below the 24-bit limit.

Top module: `cmd_event_irq`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the done count, the acknowledged count, the event flag, the three configuration bits and `irq`.
- R2: Each cycle with `done_pulse` high adds one to the done count, wrapping from 63 to 0. The done count holds when `done_pulse` is low. A write to bits 5:0 of the status word (byte offset 0x018) has no effect on it.
- R3: The status word at offset 0x018 reads back as follows: done count in bits 5:0, event flag in bit 8, acknowledged count in bits 21:16, all other bits zero. A write to this word loads bits 21:16 into the acknowledged count.
- R4: When `done_pulse` and a status write fall in the same cycle, both the increment and the new acknowledged count take effect.
- R5: The event flag is set by every increment. It is cleared by a status write with bit 8 at 0, but only in a cycle without `done_pulse`. Writing bit 8 as 1 never sets it.
- R6: Level mode applies when configuration bits 31, 29 and 28 are all 1. In this mode, `irq` is 1 exactly while the done count differs from the acknowledged count. The value reflects the register state after the most recent clock edge.
- R7: `irq` is 0 whenever configuration bit 31 or bit 29 is 0.
- R8: Pulse mode applies when bits 31 and 29 are 1 and bit 28 is 0. In this mode, `irq` is 1 only in the cycle after an increment, whatever the two counts are.
- R9: The configuration word at offset 0x000 keeps only bits 31, 29 and 28. It reads back with all other bits zero.
- R10: The word at offset 0x030 returns `xfer_left` in bits 23:0, with bits 31:24 zero, in the same cycle. Writes to that word change nothing.
- R11: A read of any other offset returns zero. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| done_pulse | input | 1 | One-cycle event from the mover (list loaded or command done) |
| xfer_left | input | 24 | Remaining bytes minus one of the command in flight |
| irq | output | 1 | Interrupt, active high |

## Verification
The counts, the event flag and the configuration bits all change at the clock edge where the pulse or write is presented. Because `irq` and `bus_rdata` are combinational from those registers, both show the new value one edge after the stimulus. The pulse-mode `irq` appears after that same edge and is gone one edge later. The active-size readback follows `xfer_left` with no delay.

The bench drives stimulus at the falling edge and samples at the next falling edge, once exactly one rising edge has passed. The active-size value is checked within the same half cycle. Same-cycle collisions of a pulse with an acknowledge write are in the vector table. The wrap from 63 to 0 is reached with a directed run of pulses.

// File: rtl/cdi_pkg.sv
// Package: shared layout of the completion status block.
// Holds the register offsets, the field positions that software decodes,
// and the packed type of the configuration bits.
package cdi_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 6;
    localparam int SIZE_W    = 24;

    localparam logic [ADDR_W-1:0] CFG_OFS    = 12'h000;
    localparam logic [ADDR_W-1:0] STATUS_OFS = 12'h018;
    localparam logic [ADDR_W-1:0] SIZE_OFS   = 12'h030;

    localparam int DONE_LSB  = 0;
    localparam int FLAG_BIT  = 8;
    localparam int PROC_LSB  = 16;
    localparam int LIST_EN_BIT = 31;
    localparam int INT_EN_BIT  = 29;
    localparam int LEVEL_BIT   = 28;

    typedef struct packed {
        logic list_en;
        logic int_en;
        logic level;
    } irq_cfg_t;
endpackage

// File: rtl/cdi_counter.sv
// Module: cdi_counter
// Keeps the hardware done count, the software acknowledged count and the
// sticky event flag.
// Assumes that inc is a single-cycle event, and that ack_wr carries one
// software status write per cycle.
module cdi_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             ack_wr,
    input  logic [CNT_W-1:0] ack_val,
    input  logic             ack_flag,
    output logic [CNT_W-1:0] done_cnt,
    output logic [CNT_W-1:0] proc_cnt,
    output logic             evt_flag
);
    // Update the counts and the flag; an increment always beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_cnt <= '0;
            proc_cnt <= '0;
            evt_flag <= 1'b0;
        end else begin
            if (inc)
                done_cnt <= done_cnt + 1'b1;
            if (ack_wr)
                proc_cnt <= ack_val;
            if (inc)
                evt_flag <= 1'b1;
            else if (ack_wr && !ack_flag)
                evt_flag <= 1'b0;
        end
    end

    // R2
    done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inc)) |-> (done_cnt == CNT_W'($past(done_cnt) + 1'b1)));
    // R2
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(inc)) |-> $stable(done_cnt));
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(inc)) |-> evt_flag);
    // R4
    ack_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ack_wr)) |-> (proc_cnt == $past(ack_val)));
endmodule

// File: rtl/cdi_irq.sv
// Module: cdi_irq
// Holds the three configuration bits and forms the interrupt line, either
// as a level from a count mismatch or as a one-cycle pulse after each
// increment.
// Assumes that cfg_wr is a decoded write to the configuration word.
module cdi_irq #(
    parameter int CNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  cdi_pkg::irq_cfg_t cfg_new,
    input  logic              inc,
    input  logic [CNT_W-1:0]  done_cnt,
    input  logic [CNT_W-1:0]  proc_cnt,
    output cdi_pkg::irq_cfg_t cfg,
    output logic              irq
);
    logic inc_q;
    logic enabled;
    logic pending;

    // Store the configuration bits and remember the last increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= '0;
            inc_q <= 1'b0;
        end else begin
            if (cfg_wr)
                cfg <= cfg_new;
            inc_q <= inc;
        end
    end

    // Select the level or pulse source and gate it with both enables.
    always_comb begin
        enabled = cfg.list_en && cfg.int_en;
        pending = (done_cnt != proc_cnt);
        irq     = enabled && (cfg.level ? pending : inc_q);
    end

    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg.list_en && cfg.int_en) |-> !irq);
    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.level && irq) |-> (done_cnt != proc_cnt));
    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !cfg.level && irq) |-> (done_cnt != $past(done_cnt)));
endmodule

// File: rtl/cdi_readmux.sv
// Module: cdi_readmux
// Combinational read path: assembles the status, configuration and
// active-size words for the selected offset, and returns zero elsewhere.
// Assumes the offsets decode to full equality with no aliasing.
module cdi_readmux #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6,
    parameter int SIZE_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  done_cnt,
    input  logic [CNT_W-1:0]  proc_cnt,
    input  logic              evt_flag,
    input  cdi_pkg::irq_cfg_t cfg,
    input  logic [SIZE_W-1:0] xfer_left,
    output logic [DATA_W-1:0] rdata
);
    import cdi_pkg::*;

    // Build the addressed word with every unlisted bit at zero.
    always_comb begin
        rdata = '0;
        unique case (addr)
            STATUS_OFS: begin
                rdata[DONE_LSB +: CNT_W] = done_cnt;
                rdata[FLAG_BIT]          = evt_flag;
                rdata[PROC_LSB +: CNT_W] = proc_cnt;
            end
            CFG_OFS: begin
                rdata[LIST_EN_BIT] = cfg.list_en;
                rdata[INT_EN_BIT]  = cfg.int_en;
                rdata[LEVEL_BIT]   = cfg.level;
            end
            SIZE_OFS: rdata[SIZE_W-1:0] = xfer_left;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/cmd_event_irq.sv
// Module: cmd_event_irq (top)
// Per-channel completion status register with a gated interrupt.
// Decodes register writes, then hands them to the counter and to the
// interrupt stage.
// Assumes done_pulse is synchronous to clk and that bus_addr is stable
// while it is read.
module cmd_event_irq
    import cdi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              done_pulse,
    input  logic [SIZE_W-1:0] xfer_left,
    output logic              irq
);
    logic             wr_status;
    logic             wr_cfg;
    irq_cfg_t         cfg_new;
    irq_cfg_t         cfg;
    logic [CNT_W-1:0] done_cnt;
    logic [CNT_W-1:0] proc_cnt;
    logic             evt_flag;

    // Decode the write strobes and pick out the configuration bits.
    always_comb begin
        wr_status       = bus_wen && (bus_addr == STATUS_OFS);
        wr_cfg          = bus_wen && (bus_addr == CFG_OFS);
        cfg_new.list_en = bus_wdata[LIST_EN_BIT];
        cfg_new.int_en  = bus_wdata[INT_EN_BIT];
        cfg_new.level   = bus_wdata[LEVEL_BIT];
    end

    cdi_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (done_pulse),
        .ack_wr   (wr_status),
        .ack_val  (bus_wdata[PROC_LSB +: CNT_W]),
        .ack_flag (bus_wdata[FLAG_BIT]),
        .done_cnt (done_cnt),
        .proc_cnt (proc_cnt),
        .evt_flag (evt_flag)
    );

    cdi_irq #(.CNT_W(CNT_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (wr_cfg),
        .cfg_new  (cfg_new),
        .inc      (done_pulse),
        .done_cnt (done_cnt),
        .proc_cnt (proc_cnt),
        .cfg      (cfg),
        .irq      (irq)
    );

    cdi_readmux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .SIZE_W (SIZE_W)
    ) u_readmux (
        .addr      (bus_addr),
        .done_cnt  (done_cnt),
        .proc_cnt  (proc_cnt),
        .evt_flag  (evt_flag),
        .cfg       (cfg),
        .xfer_left (xfer_left),
        .rdata     (bus_rdata)
    );

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_status) && !$past(bus_wdata[FLAG_BIT])
         && !$past(done_pulse)) |-> !evt_flag);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (!irq && done_cnt == '0 && proc_cnt == '0));
endmodule

// File: tb/cmd_event_irq_bench.sv
module cmd_event_irq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [11:0] bus_addr = 12'h018;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        done_pulse = 1'b0;
    logic [23:0] xfer_left = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cmd_event_irq u_cmd_event_irq (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_pulse(done_pulse),
        .xfer_left(xfer_left), .irq(irq)
    );

    // Vector: pulse, wen, addr, wdata, expected status word, expected irq, req
    localparam int NV = 10;
    localparam logic [82:0] VEC [NV] = '{
        {1'b1, 1'b0, 12'h018, 32'h0000_0000, 32'h0000_0101, 1'b1, 4'd2}, // R2 R6 first event
        {1'b1, 1'b0, 12'h018, 32'h0000_0000, 32'h0000_0102, 1'b1, 4'd2}, // R2
        {1'b0, 1'b1, 12'h018, 32'h0002_0000, 32'h0002_0002, 1'b0, 4'd3}, // R3 R5 ack
        {1'b1, 1'b1, 12'h018, 32'h0003_0000, 32'h0003_0103, 1'b0, 4'd4}, // R4 collision
        {1'b0, 1'b1, 12'h018, 32'h0003_0000, 32'h0003_0003, 1'b0, 4'd5}, // R5 clear
        {1'b0, 1'b1, 12'h018, 32'h0003_013F, 32'h0003_0003, 1'b0, 4'd5}, // R5 R2 ignored bits
        {1'b0, 1'b1, 12'h018, 32'h0001_0000, 32'h0001_0003, 1'b1, 4'd6}, // R6 mismatch
        {1'b1, 1'b0, 12'h018, 32'h0000_0000, 32'h0001_0104, 1'b1, 4'd2}, // R2
        {1'b1, 1'b1, 12'h018, 32'h0004_0000, 32'h0004_0105, 1'b1, 4'd4}, // R4 increment kept
        {1'b0, 1'b1, 12'h018, 32'h0005_0000, 32'h0005_0005, 1'b0, 4'd6}  // R6 caught up
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive inputs now (at a falling edge), pass one rising edge, return at the next falling edge.
    task automatic cyc(input logic p, input logic w, input logic [11:0] a, input logic [31:0] d);
        done_pulse = p; bus_wen = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        done_pulse = 1'b0; bus_wen = 1'b0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        bus_addr = 12'h018; #1;
        chk("R1 status", bus_rdata, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        bus_addr = 12'h000; #1;
        chk("R1 config", bus_rdata, 32'h0);
        rst_n = 1'b1;

        cyc(1'b0, 1'b1, 12'h000, 32'hB000_0000); // level mode, enabled
        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][82], VEC[i][81], VEC[i][80:69], VEC[i][68:37]);
            bus_addr = 12'h018; #1;
            chk($sformatf("R%0d vec%0d status", VEC[i][3:0], i), bus_rdata, VEC[i][36:5]);
            chk($sformatf("R%0d vec%0d irq", VEC[i][3:0], i), {31'b0, irq}, {31'b0, VEC[i][4]});
        end

        // R2 wrap from 63 to 0: done 5 + 59 = 64
        for (int i = 0; i < 59; i++) cyc(1'b1, 1'b0, 12'h018, 32'h0);
        #1;
        chk("R2 wrap status", bus_rdata, 32'h0005_0100);
        chk("R6 wrap irq", {31'b0, irq}, 32'h1);
        cyc(1'b0, 1'b1, 12'h018, 32'h0000_0100);
        chk("R6 equal after wrap", {31'b0, irq}, 32'h0);
        chk("R5 flag kept by bit8=1", bus_rdata, 32'h0000_0100);

        // R7 enable gating
        cyc(1'b0, 1'b1, 12'h000, 32'h9000_0000);
        cyc(1'b1, 1'b0, 12'h018, 32'h0);
        chk("R7 int_en off", {31'b0, irq}, 32'h0);
        cyc(1'b0, 1'b1, 12'h000, 32'h3000_0000);
        chk("R7 list_en off", {31'b0, irq}, 32'h0);
        cyc(1'b0, 1'b1, 12'h000, 32'hB000_0000);
        chk("R6 re-enabled", {31'b0, irq}, 32'h1);

        // R9 config keeps only three bits
        cyc(1'b0, 1'b1, 12'h000, 32'hFFFF_FFFF);
        chk("R9 config read", bus_rdata, 32'hB000_0000);

        // R8 pulse mode
        cyc(1'b0, 1'b1, 12'h018, 32'h0001_0000);
        chk("R5 ack clears irq", {31'b0, irq}, 32'h0);
        cyc(1'b0, 1'b1, 12'h000, 32'hA000_0000);
        cyc(1'b1, 1'b0, 12'h018, 32'h0);
        chk("R8 pulse high", {31'b0, irq}, 32'h1);
        cyc(1'b0, 1'b0, 12'h018, 32'h0);
        chk("R8 pulse gone", {31'b0, irq}, 32'h0);
        chk("R8 status", bus_rdata, 32'h0001_0102);

        // R10 active size
        bus_addr = 12'h030; xfer_left = 24'hABCDEF; #1;
        chk("R10 size", bus_rdata, 32'h00AB_CDEF);
        xfer_left = 24'hFFFFFF; #1;
        chk("R10 all ones", bus_rdata, 32'h00FF_FFFF);
        cyc(1'b0, 1'b1, 12'h030, 32'h0000_0000);
        bus_addr = 12'h018; #1;
        chk("R10 write ignored", bus_rdata, 32'h0001_0102);

        // R11 unmapped offsets
        bus_addr = 12'h004; #1;
        chk("R11 read zero", bus_rdata, 32'h0);
        cyc(1'b0, 1'b1, 12'h004, 32'hFFFF_FFFF);
        bus_addr = 12'h018; #1;
        chk("R11 status unchanged", bus_rdata, 32'h0001_0102);
        bus_addr = 12'h000; #1;
        chk("R11 config unchanged", bus_rdata, 32'hA000_0000);

        // R1 reset mid-run
        cyc(1'b1, 1'b0, 12'h018, 32'h0);
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 12'h018, 32'h0);
        #1;
        chk("R1 status after reset", bus_rdata, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        bus_addr = 12'h000; #1;
        chk("R1 config after reset", bus_rdata, 32'h0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule